// File: doc/BRIEF.md
# Two-Wire Control Register Slave

This block is a two-wire (SMBus/I2C compatible) slave that answers at a single fixed device address and gives a host read and write access to a small bank of 8-bit control registers. SCL and SDA are sampled with the system clock, passed through a two-flop synchronizer and a majority-free glitch filter, and then decoded into START, STOP and bit events. SDA is driven through an open-drain style enable: the slave only ever pulls the line low.

Each transaction names a starting register in its command byte. The top bit of that byte selects between a single-byte access and a counted block access. In a block write the host sends a byte count after the command, then the data. In a block read the slave first returns the contents of the count register, then the registers from the start index upward until the host answers with a NACK. The whole bank is presented on a parallel output, and four clock-output enables are decoded from fixed bits of registers 1 and 2 for neighbouring logic.

Top module: `smb_regslave`

## Requirements
- R1: After reset the bank holds 00h, 05h, C0h, 08h, 06h, D8h in registers 0 to 5 and 00h in the rest (register i on regs_o[8i+7:8i]), clk_out_en is 1111b and sda_drive_low is 0.
- R2: The address byte 1101011 followed by the direction bit (D6h write, D7h read) is acknowledged; any other address is not, and every following byte of that transaction is left unacknowledged and changes no register until the next START.
- R3: A command byte with bit 7 = 1 selects single-byte mode with bits 6:0 as the register index; a byte write stores exactly one data byte and leaves a second data byte unacknowledged and unstored.
- R4: A single-byte read (command, repeated START, D7h) returns the indexed register, most significant bit first.
- R5: A command byte with bit 7 = 0 selects block mode; the next written byte is a count, and up to that many following bytes are stored at ascending indices; a byte past the count (including the first one when the count is 0) is not acknowledged and not stored.
- R6: A block read returns the value of register 4 first, then the registers from the start index upward, for as long as the host acknowledges; after the host NACK the slave stops driving SDA.
- R7: A data byte aimed at an index at or above the bank size is not acknowledged and not stored; a read of such an index returns 00h.
- R8: A STOP or START arriving part-way through a byte discards the partial byte, writes nothing and leaves SDA released; a START begins a new address phase.
- R9: clk_out_en[0] follows register 1 bit 2, clk_out_en[1] register 1 bit 0, clk_out_en[2] register 2 bit 7 and clk_out_en[3] register 2 bit 6.
- R10: The slave changes its SDA drive only while the filtered SCL is low, so it never forms a START or STOP itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to sample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin (wired-AND of all drivers) |
| sda_drive_low | output | 1 | 1 pulls SDA low, 0 releases it |
| regs_o | output | NREGS*8 | Whole register bank, register i in bits 8i+7:8i |
| clk_out_en | output | 4 | Clock output enables decoded from registers 1 and 2 |

## Verification
The hardest situation to reach is a bus condition arriving in the middle of a byte: the host has to stop clocking after a few bits and raise or lower SDA while SCL is high, which no well-formed transfer does. The bench has a bit-level host model that can abandon a byte after any number of bits and then issue STOP or a fresh START, after which it reads the bank back on the parallel output and through a normal read. Block transfers that run past the count or off the end of the bank are produced by random start indices beyond the bank and random counts larger than the bytes remaining.

// File: rtl/smb_pkg.sv
package smb_pkg;

    // 7-bit device address; the direction bit is appended on the bus
    localparam logic [6:0] DEV_ADDR = 7'h6B;

    // register whose value leads every block read
    localparam int CNT_REG = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_CMD,
        ST_CNT,
        ST_WDAT,
        ST_RDAT,
        ST_IGN
    } eng_st_e;

    function automatic logic [7:0] reset_byte(input int i);
        logic [7:0] v;
        case (i)
            1:       v = 8'h05;
            2:       v = 8'hC0;
            3:       v = 8'h08;
            4:       v = 8'h06;
            5:       v = 8'hD8;
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/smb_glitch_filter.sv
module smb_glitch_filter #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    typedef struct packed {
        logic [1:0]        sync;
        logic [STAGES-1:0] hist;
        logic              lvl;
    } flt_s;

    flt_s flt_d, flt_q;

    always_comb begin
        flt_d      = flt_q;
        flt_d.sync = {flt_q.sync[0], din};
        flt_d.hist = {flt_q.hist[STAGES-2:0], flt_q.sync[1]};
        // the level only moves once every stored sample agrees
        if (&flt_q.hist) begin
            flt_d.lvl = 1'b1;
        end else if (~|flt_q.hist) begin
            flt_d.lvl = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flt_q <= '1;
        end else begin
            flt_q <= flt_d;
        end
    end

    assign dout = flt_q.lvl;

endmodule

// File: rtl/smb_reg_bank.sv
module smb_reg_bank
    import smb_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [6:0]         wr_idx,
    input  logic [7:0]         wr_data,
    output logic [NREGS*8-1:0] regs_o
);

    generate
        for (genvar g = 0; g < NREGS; g++) begin : g_reg
            logic [7:0] reg_d, reg_q;

            always_comb begin
                reg_d = reg_q;
                if (wr_en && (wr_idx == 7'(g))) begin
                    reg_d = wr_data;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    reg_q <= reset_byte(g);
                end else begin
                    reg_q <= reg_d;
                end
            end

            assign regs_o[8*g +: 8] = reg_q;
        end
    endgenerate

endmodule

// File: rtl/smb_proto_engine.sv
module smb_proto_engine
    import smb_pkg::*;
#(
    parameter int NREGS = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_f,
    input  logic               sda_f,
    input  logic [NREGS*8-1:0] regs_i,
    output logic               sda_oe,
    output logic               wr_en,
    output logic [6:0]         wr_idx,
    output logic [7:0]         wr_data,
    output eng_st_e            st_o
);

    localparam logic [7:0] NREG8 = 8'(NREGS);

    typedef struct packed {
        eng_st_e    st;
        logic [3:0] cnt;    // SCL rising edges seen in this byte, 8 = ack slot
        logic [7:0] sh;     // received byte
        logic       ack;    // decision for the coming ack slot
        logic [7:0] tx;     // byte being sent
        logic [6:0] idx;    // current register index
        logic       blk;    // block mode
        logic [7:0] left;   // data bytes still accepted
        logic       oe;
        logic       scl_p;
        logic       sda_p;
    } eng_s;

    eng_s e_d, e_q;

    function automatic logic [7:0] rd_reg(input logic [6:0] i);
        logic [7:0] v;
        v = 8'h00;
        for (int k = 0; k < NREGS; k++) begin
            if (i == 7'(k)) v = regs_i[8*k +: 8];
        end
        return v;
    endfunction

    logic       rise, fall, start_c, stop_c, wok;
    logic [7:0] byte_in;

    always_comb begin
        e_d       = e_q;
        e_d.scl_p = scl_f;
        e_d.sda_p = sda_f;
        rise      = scl_f & ~e_q.scl_p;
        fall      = ~scl_f & e_q.scl_p;
        start_c   = scl_f & e_q.scl_p & e_q.sda_p & ~sda_f;
        stop_c    = scl_f & e_q.scl_p & ~e_q.sda_p & sda_f;
        byte_in   = {e_q.sh[6:0], sda_f};
        wok       = (e_q.left != 8'd0) && ({1'b0, e_q.idx} < NREG8);
        wr_en     = 1'b0;
        wr_idx    = e_q.idx;
        wr_data   = byte_in;

        if (start_c) begin
            e_d.st  = ST_ADDR;
            e_d.cnt = 4'd0;
            e_d.oe  = 1'b0;
        end else if (stop_c) begin
            e_d.st  = ST_IDLE;
            e_d.cnt = 4'd0;
            e_d.oe  = 1'b0;
        end else if (e_q.st == ST_IDLE || e_q.st == ST_IGN) begin
            e_d.oe = 1'b0;
        end else if (rise) begin
            if (e_q.cnt < 4'd8) begin
                e_d.sh  = byte_in;
                e_d.cnt = e_q.cnt + 4'd1;
                if (e_q.cnt == 4'd7) begin
                    case (e_q.st)
                        ST_ADDR: e_d.ack = (byte_in[7:1] == DEV_ADDR);
                        ST_CMD,
                        ST_CNT:  e_d.ack = 1'b1;
                        ST_WDAT: begin
                            e_d.ack = wok;
                            wr_en   = wok;
                        end
                        default: e_d.ack = 1'b0;
                    endcase
                end
            end else begin
                // ninth clock: act on the completed byte
                e_d.cnt = 4'd0;
                case (e_q.st)
                    ST_ADDR: begin
                        if (!e_q.ack) begin
                            e_d.st = ST_IGN;
                        end else if (e_q.sh[0]) begin
                            e_d.st = ST_RDAT;
                            if (e_q.blk) begin
                                e_d.tx = rd_reg(7'(CNT_REG));
                            end else begin
                                e_d.tx  = rd_reg(e_q.idx);
                                e_d.idx = e_q.idx + 7'd1;
                            end
                        end else begin
                            e_d.st = ST_CMD;
                        end
                    end
                    ST_CMD: begin
                        e_d.idx  = e_q.sh[6:0];
                        e_d.blk  = ~e_q.sh[7];
                        e_d.left = 8'd1;
                        e_d.st   = e_q.sh[7] ? ST_WDAT : ST_CNT;
                    end
                    ST_CNT: begin
                        e_d.left = e_q.sh;
                        e_d.st   = ST_WDAT;
                    end
                    ST_WDAT: begin
                        if (!e_q.ack) begin
                            e_d.st = ST_IGN;
                        end else begin
                            e_d.idx  = e_q.idx + 7'd1;
                            e_d.left = e_q.left - 8'd1;
                        end
                    end
                    ST_RDAT: begin
                        if (sda_f) begin
                            e_d.st = ST_IGN;
                        end else begin
                            e_d.tx  = rd_reg(e_q.idx);
                            e_d.idx = e_q.idx + 7'd1;
                        end
                    end
                    default: e_d.st = ST_IDLE;
                endcase
            end
        end else if (fall) begin
            if (e_q.cnt == 4'd8) begin
                e_d.oe = (e_q.st != ST_RDAT) && e_q.ack;
            end else begin
                e_d.oe = (e_q.st == ST_RDAT) && !e_q.tx[3'd7 - e_q.cnt[2:0]];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            e_q <= '{st: ST_IDLE, cnt: 4'd0, sh: 8'd0, ack: 1'b0, tx: 8'd0,
                     idx: 7'd0, blk: 1'b0, left: 8'd0, oe: 1'b0,
                     scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            e_q <= e_d;
        end
    end

    assign sda_oe = e_q.oe;
    assign st_o   = e_q.st;

endmodule

// File: rtl/smb_regslave.sv
module smb_regslave
    import smb_pkg::*;
#(
    parameter int NREGS       = 8,
    parameter int FILT_STAGES = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_drive_low,
    output logic [NREGS*8-1:0] regs_o,
    output logic [3:0]         clk_out_en
);

    logic [1:0] raw_lines, filt_lines;
    logic       scl_f, sda_f;
    logic       wr_en;
    logic [6:0] wr_idx;
    logic [7:0] wr_data;
    eng_st_e    eng_st;

    assign raw_lines = {sda_i, scl_i};

    generate
        for (genvar g = 0; g < 2; g++) begin : g_line
            smb_glitch_filter #(.STAGES(FILT_STAGES)) u_flt (
                .clk  (clk),
                .rst_n(rst_n),
                .din  (raw_lines[g]),
                .dout (filt_lines[g])
            );
        end
    endgenerate

    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    smb_proto_engine #(.NREGS(NREGS)) u_eng (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_f  (scl_f),
        .sda_f  (sda_f),
        .regs_i (regs_o),
        .sda_oe (sda_drive_low),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .st_o   (eng_st)
    );

    smb_reg_bank #(.NREGS(NREGS)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_idx (wr_idx),
        .wr_data(wr_data),
        .regs_o (regs_o)
    );

    // enable bit positions are fixed by the neighbouring output logic
    assign clk_out_en = {regs_o[8*2+6], regs_o[8*2+7], regs_o[8*1+0], regs_o[8*1+2]};

endmodule

// File: rtl/smb_regslave_chk.sv
module smb_regslave_chk
    import smb_pkg::*;
#(
    parameter int NREGS = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               scl_f,
    input logic               sda_f,
    input logic               sda_oe,
    input logic               wr_en,
    input logic [6:0]         wr_idx,
    input eng_st_e            st,
    input logic [NREGS*8-1:0] regs
);

    function automatic logic [NREGS*8-1:0] reset_image();
        logic [NREGS*8-1:0] v;
        for (int i = 0; i < NREGS; i++) v[8*i +: 8] = reset_byte(i);
        return v;
    endfunction

    localparam logic [NREGS*8-1:0] RST_IMG = reset_image();

    // R1: bank holds the reset image when reset is released
    assert_reset_image_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (regs == RST_IMG));

    // R2: an ignored transaction neither drives the bus nor writes
    assert_ignore_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IGN) |-> (!sda_oe && !wr_en));

    // R3: writes only come out of the data phase
    assert_write_in_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (st == ST_WDAT));

    // R5: the bank only changes after a write strobe
    assert_regs_need_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (regs != $past(regs)) |-> $past(wr_en));

    // R7: no write strobe beyond the bank
    assert_write_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> ({1'b0, wr_idx} < 8'(NREGS)));

    // R8: a STOP releases SDA and idles the engine
    assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && sda_f && !$past(sda_f)) |=> (!sda_oe && st == ST_IDLE));

    // R10: SDA drive only moves while SCL is low
    assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_f);

endmodule

bind smb_regslave smb_regslave_chk #(.NREGS(NREGS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .scl_f (scl_f),
    .sda_f (sda_f),
    .sda_oe(sda_drive_low),
    .wr_en (wr_en),
    .wr_idx(wr_idx),
    .st    (eng_st),
    .regs  (regs_o)
);

// File: tb/smb_regslave_test.sv
module smb_regslave_test;

    localparam int NR = 8;
    localparam int H  = 16;   // system clocks per SCL half period

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic sda_oe;
    logic [NR*8-1:0] regs;
    logic [3:0] en;
    logic sda_line;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    smb_regslave #(.NREGS(NR), .FILT_STAGES(3)) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_i        (scl),
        .sda_i        (sda_line),
        .sda_drive_low(sda_oe),
        .regs_o       (regs),
        .clk_out_en   (en)
    );

    int n_tests = 0;
    int n_fail  = 0;
    logic [7:0] model [NR];

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] model_flat();
        logic [63:0] f;
        for (int i = 0; i < NR; i++) f[8*i +: 8] = model[i];
        return f;
    endfunction

    function automatic logic [7:0] mrd(input int i);
        return (i < NR) ? model[i] : 8'h00;
    endfunction

    function automatic logic [3:0] model_en();
        return {model[2][6], model[2][7], model[1][0], model[1][2]};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H/2);
        scl = 1'b1;   tick(H);
        sda_m = 1'b0; tick(H);
        scl = 1'b0;   tick(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H/2);
        scl = 1'b1;   tick(H);
        sda_m = 1'b1; tick(2*H);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; tick(H/2);
        scl = 1'b1; tick(H);
        scl = 1'b0; tick(H/2);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; tick(H/2);
        scl = 1'b1;   tick(H/2);
        b = sda_line; tick(H/2);
        scl = 1'b0;   tick(H/2);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(~mack);
    endtask

    // returns position of the first unacknowledged payload byte, n if none
    task automatic do_write(input logic [7:0] cmd, input int n, input logic [7:0] b [10],
                            output int npos);
        logic a;
        bus_start();
        write_byte(8'hD6, a);
        check("R2 write address ack", a, 1'b1);
        write_byte(cmd, a);
        check("R3 command ack", a, 1'b1);
        npos = n;
        for (int i = 0; i < n; i++) begin
            write_byte(b[i], a);
            if (!a) begin
                npos = i;
                break;
            end
        end
        bus_stop();
    endtask

    task automatic do_read(input logic [7:0] cmd, input int n, output logic [7:0] got [10]);
        logic a;
        bus_start();
        write_byte(8'hD6, a);
        write_byte(cmd, a);
        bus_start();
        write_byte(8'hD7, a);
        check("R2 read address ack", a, 1'b1);
        for (int i = 0; i < n; i++) read_byte(i != n - 1, got[i]);
        bus_stop();
        check("R6 SDA released after NACK", sda_oe, 1'b0);
    endtask

    // model of a write: updates the bank, returns the expected first NACK position
    function automatic int expect_write(input logic [7:0] cmd, input int n, input logic [7:0] b [10]);
        int idx = int'(cmd[6:0]);
        int lim;
        int first;
        if (cmd[7]) begin
            lim = 1; first = 0;
        end else begin
            lim = int'(b[0]); first = 1;
        end
        for (int i = first; i < n; i++) begin
            if ((i - first) >= lim || idx + i - first >= NR) return i;
            model[idx + i - first] = b[i];
        end
        return n;
    endfunction

    task automatic write_and_check(input string tag, input logic [7:0] cmd, input int n,
                                   input logic [7:0] b [10]);
        int got, exp;
        exp = expect_write(cmd, n, b);
        do_write(cmd, n, b, got);
        check({tag, " ack count"}, 64'(got), 64'(exp));
        check({tag, " bank"}, regs, model_flat());
    endtask

    task automatic read_and_check(input string tag, input logic [7:0] cmd, input int n);
        logic [7:0] got [10];
        logic [7:0] exp;
        int idx = int'(cmd[6:0]);
        do_read(cmd, n, got);
        for (int i = 0; i < n; i++) begin
            if (cmd[7])      exp = mrd(idx + i);
            else if (i == 0) exp = model[4];
            else             exp = mrd(idx + i - 1);
            check(tag, got[i], exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] b [10];
        logic a;
        int dummy;
        logic [7:0] d;

        for (int i = 0; i < NR; i++) model[i] = 8'h00;
        model[1] = 8'h05; model[2] = 8'hC0; model[3] = 8'h08;
        model[4] = 8'h06; model[5] = 8'hD8;
        for (int i = 0; i < 10; i++) b[i] = 8'h00;

        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1 reset state
        check("R1 reset bank", regs, model_flat());
        check("R1 reset enables", en, 4'hF);
        check("R1 SDA released", sda_oe, 1'b0);

        // R2 foreign address: no ack, rest of transfer ignored
        bus_start();
        write_byte(8'hA0, a);
        check("R2 foreign address nack", a, 1'b0);
        write_byte(8'h81, a);
        check("R2 ignored byte nack", a, 1'b0);
        write_byte(8'h55, a);
        check("R2 ignored data nack", a, 1'b0);
        bus_stop();
        check("R2 bank untouched", regs, model_flat());

        // R3 and R9 single-byte writes to the enable registers
        b[0] = 8'h04; write_and_check("R3 byte write reg1", 8'h81, 1, b);
        b[0] = 8'h40; write_and_check("R3 byte write reg2", 8'h82, 1, b);
        check("R9 enable mapping", en, 4'b1001);
        check("R9 enable vs model", en, model_en());
        b[0] = 8'h11; b[1] = 8'h22;
        write_and_check("R3 second data byte rejected", 8'h83, 2, b);

        // R4 single-byte read, MSB first
        read_and_check("R4 byte read reg5", 8'h85, 1);
        read_and_check("R4 byte read reg3", 8'h83, 1);

        // R5 block write past the count, and count zero
        b[0] = 8'd3; b[1] = 8'hA1; b[2] = 8'hB2; b[3] = 8'hC3; b[4] = 8'hD4;
        write_and_check("R5 block write over count", 8'h00, 5, b);
        b[0] = 8'd0; b[1] = 8'h77;
        write_and_check("R5 block write count zero", 8'h05, 2, b);

        // R6 block read with count register first
        read_and_check("R6 block read", 8'h00, 4);

        // R7 out-of-range write and read
        b[0] = 8'd4; b[1] = 8'h61; b[2] = 8'h72; b[3] = 8'h83; b[4] = 8'h94;
        write_and_check("R7 block write off the end", 8'h06, 5, b);
        b[0] = 8'h5A;
        write_and_check("R7 byte write out of range", 8'h89, 1, b);
        read_and_check("R7 block read off the end", 8'h06, 4);
        read_and_check("R7 byte read out of range", 8'h8A, 1);

        // R8 STOP in the middle of a data byte
        bus_start();
        write_byte(8'hD6, a);
        write_byte(8'h80, a);
        for (int i = 0; i < 4; i++) put_bit(1'b1);
        bus_stop();
        check("R8 stop mid-byte bank", regs, model_flat());
        check("R8 stop mid-byte SDA", sda_oe, 1'b0);

        // R8 START in the middle of a data byte, then a full write
        bus_start();
        write_byte(8'hD6, a);
        write_byte(8'h80, a);
        for (int i = 0; i < 5; i++) put_bit(1'b0);
        bus_start();
        check("R8 start mid-byte bank", regs, model_flat());
        write_byte(8'hD6, a);
        check("R8 address after restart", a, 1'b1);
        write_byte(8'h80, a);
        write_byte(8'h3C, a);
        check("R8 data after restart", a, 1'b1);
        bus_stop();
        model[0] = 8'h3C;
        check("R8 bank after restart", regs, model_flat());

        // mixed random traffic
        void'($urandom(32'd4242));
        for (int t = 0; t < 30; t++) begin
            int op  = int'($urandom_range(0, 3));
            logic [6:0] idx = 7'($urandom_range(0, 9));
            int n;
            case (op)
                0: begin
                    b[0] = 8'($urandom);
                    b[1] = 8'($urandom);
                    n = int'($urandom_range(1, 2));
                    write_and_check("R3 random byte write", {1'b1, idx}, n, b);
                end
                1: read_and_check("R4 random byte read", {1'b1, idx}, 1);
                2: begin
                    b[0] = 8'($urandom_range(0, 4));
                    for (int i = 1; i < 6; i++) b[i] = 8'($urandom);
                    n = int'($urandom_range(1, 6));
                    write_and_check("R5 random block write", {1'b0, idx}, n, b);
                end
                default: read_and_check("R6 random block read", {1'b0, idx},
                                        int'($urandom_range(1, 4)));
            endcase
        end
        check("R9 enables after traffic", en, model_en());

        dummy = 0;
        d = 8'h00;
        if (dummy != 0) check("unused", d, 8'h00);
        finish_run();
    end

endmodule